// File: doc/BRIEF.md
# Parallel Eight-Line Serial Receiver

This block receives several asynchronous serial lines that share one baud rate, one byte per frame: a start bit, eight data bits sent least significant first, and a stop bit. It does not run one state machine per line. It keeps one bit vector per receiver state, and each bit position of a vector belongs to one line. The next-state vectors for all lines come from a handful of bitwise expressions and are registered together.

A sample enable, `tick`, is supplied from outside and pulses at three times the bit rate. Only on a tick does any line's state advance, any shift register move, or any flag get set. Each shift register starts out holding a single marker bit in its top position. When that marker falls out of the bottom, the byte is complete, so no per-line bit counter is needed. The host watches the ready and error vectors, reads the byte for a line, and then pulses that line's acknowledge bit. The acknowledge clears the line's flags and re-arms its shift register.

Top module: `vuart_rx`

## Requirements
- R1: After reset every byte output reads 0x80, and the ready, framing-error and overrun-error vectors are all zero.
- R2: The line pins use inverted polarity. A pin at 0 is the idle or stop level, and a pin at 1 is a start or space bit. Data bits arrive least significant first, and the byte output holds the logical data bits with bit 0 first on the wire.
- R3: All lines are received independently and at the same time. A frame on one line is decoded correctly whatever the other lines do and whatever tick its start falls on. Each line is always in exactly one of the six receiver states.
- R4: A start level seen on only one tick is rejected and no reception begins. A start level held for two consecutive ticks begins reception, with data sampled on every third tick after that.
- R5: A line's ready bit is set on the tick that checks its stop bit. The byte stays unchanged until that line is acknowledged.
- R6: If the checked stop bit is at the start level, the framing-error bit is set together with ready.
- R7: If a line samples a data bit while its ready bit is still set, its overrun-error bit is set. There is only one buffer per line.
- R8: An acknowledge pulse on bit n clears ready, framing error and overrun error for line n and reloads its byte register with 0x80. Other lines are not affected. A flag-setting condition in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Sample enable at three times the bit rate |
| line_i | input | NCH | Serial line pins, inverted polarity |
| ack_i | input | NCH | Per-line acknowledge pulse from the host |
| byte_o | output | NCH*DW | Shift register of line n at bits n*DW upward |
| rdy_o | output | NCH | Byte ready flags |
| ferr_o | output | NCH | Framing-error flags |
| oerr_o | output | NCH | Overrun-error flags |

## Verification
The hardest situation to reach is every line at a different point of its frame at the same moment. Without that, a mistake that mixes bits between positions of the shared state vectors would go unnoticed. The stimulus sends distinct bytes on all eight lines, with start bits spread across three tick phases. It also gives a one-tick start pulse and a two-tick start pulse on neighbouring lines in the same run. Overrun is reached by sending two frames on one line with no acknowledge between them, so that the second frame's first data sample finds ready still set.

// File: rtl/vuart_pkg.sv
package vuart_pkg;
  // Index of each receiver state inside the packed state-vector array
  typedef enum logic [2:0] {
    S_WAIT = 3'd0,  // idle, looking for a start level
    S_CONF = 3'd1,  // start level seen once, confirming
    S_IGN1 = 3'd2,  // first spacing tick
    S_IGN2 = 3'd3,  // second spacing tick
    S_SAMP = 3'd4,  // mid-bit data sample
    S_STOP = 3'd5   // stop bit check
  } vstate_e;

  localparam int NUM_ST = 6;
endpackage

// File: rtl/vuart_sync.sv
module vuart_sync #(
  parameter int NCH    = 8,
  parameter int STAGES = 2,
  parameter bit INVERT = 1'b1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] line_i,
  output logic [NCH-1:0] din_o
);
  logic [STAGES-1:0][NCH-1:0] pipe;

  // Pins reset to 0, which is the idle level on inverted-polarity lines
  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[STAGES-2:0], line_i};
  end

  generate
    if (INVERT) begin : g_inv
      assign din_o = ~pipe[STAGES-1];
    end else begin : g_pass
      assign din_o = pipe[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/vuart_state.sv
module vuart_state
  import vuart_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         tick,
  input  logic [NCH-1:0]               din,
  input  logic [NCH-1:0]               full,
  output logic [NUM_ST-1:0][NCH-1:0]   st_q
);
  logic [NUM_ST-1:0][NCH-1:0] st_d;

  // All six vectors are computed from the current-tick values
  always_comb begin
    st_d[S_WAIT] = ((st_q[S_WAIT] | st_q[S_CONF]) & din) | st_q[S_STOP];
    st_d[S_CONF] = st_q[S_WAIT] & ~din;
    st_d[S_IGN1] = (st_q[S_CONF] & ~din) | st_q[S_SAMP];
    st_d[S_IGN2] = st_q[S_IGN1];
    st_d[S_SAMP] = st_q[S_IGN2] & ~full;
    st_d[S_STOP] = st_q[S_IGN2] & full;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= '0;
      st_q[S_WAIT] <= '1;
    end else if (tick) begin
      st_q <= st_d;
    end
  end
endmodule

// File: rtl/vuart_shreg.sv
module vuart_shreg #(
  parameter int NCH = 8,
  parameter int DW  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [NCH-1:0]    samp,
  input  logic [NCH-1:0]    din,
  input  logic [NCH-1:0]    ack,
  output logic [NCH*DW-1:0] data_o,
  output logic [NCH-1:0]    carry_o
);
  localparam logic [DW-1:0] MARK = {1'b1, {(DW-1){1'b0}}};

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [DW-1:0] sr_q;
      logic [DW-1:0] base;
      logic          shift;

      assign base  = ack[c] ? MARK : sr_q;
      assign shift = tick & samp[c];
      // The bit leaving position 0 on a shift reports the marker dropping out
      assign carry_o[c] = shift & base[0];
      assign data_o[c*DW +: DW] = sr_q;

      always_ff @(posedge clk) begin
        if (rst)        sr_q <= MARK;
        else if (shift) sr_q <= {din[c], base[DW-1:1]};
        else if (ack[c]) sr_q <= MARK;
      end
    end
  endgenerate
endmodule

// File: rtl/vuart_flags.sv
module vuart_flags #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic [NCH-1:0] din,
  input  logic [NCH-1:0] st_samp,
  input  logic [NCH-1:0] st_ign2,
  input  logic [NCH-1:0] st_stop,
  input  logic [NCH-1:0] carry,
  input  logic [NCH-1:0] ack,
  output logic [NCH-1:0] full_q,
  output logic [NCH-1:0] rdy_q,
  output logic [NCH-1:0] ferr_q,
  output logic [NCH-1:0] oerr_q
);
  logic [NCH-1:0] tvec;
  logic [NCH-1:0] set_rdy;
  logic [NCH-1:0] set_fe;
  logic [NCH-1:0] set_oe;

  assign tvec    = {NCH{tick}};
  assign set_rdy = tvec & st_stop;
  assign set_fe  = tvec & st_stop & ~din;
  assign set_oe  = tvec & st_samp & rdy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= '0;
      rdy_q  <= '0;
      ferr_q <= '0;
      oerr_q <= '0;
    end else begin
      if (tick) full_q <= (full_q | carry) & ~st_ign2;
      rdy_q  <= (rdy_q  & ~ack) | set_rdy;
      ferr_q <= (ferr_q & ~ack) | set_fe;
      oerr_q <= (oerr_q & ~ack) | set_oe;
    end
  end
endmodule

// File: rtl/vuart_rx.sv
module vuart_rx
  import vuart_pkg::*;
#(
  parameter int NCH = 8,
  parameter int DW  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [NCH-1:0]    line_i,
  input  logic [NCH-1:0]    ack_i,
  output logic [NCH*DW-1:0] byte_o,
  output logic [NCH-1:0]    rdy_o,
  output logic [NCH-1:0]    ferr_o,
  output logic [NCH-1:0]    oerr_o
);
  logic [NCH-1:0]             din;
  logic [NCH-1:0]             full;
  logic [NCH-1:0]             carry;
  logic [NUM_ST-1:0][NCH-1:0] st_vec;

  vuart_sync #(.NCH(NCH), .STAGES(2), .INVERT(1'b1)) u_sync (
    .clk(clk), .rst(rst), .line_i(line_i), .din_o(din)
  );

  vuart_state #(.NCH(NCH)) u_state (
    .clk(clk), .rst(rst), .tick(tick), .din(din), .full(full), .st_q(st_vec)
  );

  vuart_shreg #(.NCH(NCH), .DW(DW)) u_shreg (
    .clk(clk), .rst(rst), .tick(tick), .samp(st_vec[S_SAMP]), .din(din),
    .ack(ack_i), .data_o(byte_o), .carry_o(carry)
  );

  vuart_flags #(.NCH(NCH)) u_flags (
    .clk(clk), .rst(rst), .tick(tick), .din(din),
    .st_samp(st_vec[S_SAMP]), .st_ign2(st_vec[S_IGN2]), .st_stop(st_vec[S_STOP]),
    .carry(carry), .ack(ack_i), .full_q(full), .rdy_q(rdy_o),
    .ferr_q(ferr_o), .oerr_q(oerr_o)
  );
endmodule

// File: rtl/vuart_rx_chk.sv
module vuart_rx_chk
  import vuart_pkg::*;
#(
  parameter int NCH = 8,
  parameter int DW  = 8
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       tick,
  input logic [NCH-1:0]             ack,
  input logic [NCH-1:0]             rdy,
  input logic [NCH-1:0]             ferr,
  input logic [NCH-1:0]             oerr,
  input logic [NCH*DW-1:0]          data,
  input logic [NUM_ST-1:0][NCH-1:0] st
);
  localparam logic [DW-1:0] MARK = {1'b1, {(DW-1){1'b0}}};

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      // R3
      one_state_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({st[S_WAIT][c], st[S_CONF][c], st[S_IGN1][c],
                    st[S_IGN2][c], st[S_SAMP][c], st[S_STOP][c]}) == 1);

      // R5
      rdy_from_stop_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rdy[c]) |-> $past(tick && st[S_STOP][c]));

      // R5
      data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !ack[c]) |=> $stable(data[c*DW +: DW]));

      // R6
      ferr_with_rdy_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ferr[c]) |-> rdy[c]);

      // R7
      oerr_needs_rdy_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(oerr[c]) |-> $past(rdy[c]));

      // R8
      ack_clear_rdy_chk: assert property (@(posedge clk) disable iff (rst)
        (ack[c] && !(tick && st[S_STOP][c])) |=> (!rdy[c] && !ferr[c]));

      // R8
      ack_clear_oerr_chk: assert property (@(posedge clk) disable iff (rst)
        (ack[c] && !(tick && st[S_SAMP][c])) |=> (!oerr[c] && data[c*DW +: DW] == MARK));
    end
  endgenerate
endmodule

bind vuart_rx vuart_rx_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .ack(ack_i), .rdy(rdy_o),
  .ferr(ferr_o), .oerr(oerr_o), .data(byte_o), .st(st_vec)
);

// File: tb/vuart_rx_test.sv
`timescale 1ns/1ps
module vuart_rx_test;
  localparam int NCH = 8;
  localparam int DW  = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [1:0]        tcnt = '0;
  logic              tick;
  logic [NCH-1:0]    line_i = '0;
  logic [NCH-1:0]    ack_i = '0;
  logic [NCH*DW-1:0] byte_o;
  logic [NCH-1:0]    rdy_o, ferr_o, oerr_o;

  int vectors = 0;
  int miscomp = 0;

  always #4 clk = ~clk;  // 125 MHz
  always @(posedge clk) tcnt <= tcnt + 2'd1;
  assign tick = (tcnt == 2'd0);

  vuart_rx #(.NCH(NCH), .DW(DW)) uut (
    .clk(clk), .rst(rst), .tick(tick), .line_i(line_i), .ack_i(ack_i),
    .byte_o(byte_o), .rdy_o(rdy_o), .ferr_o(ferr_o), .oerr_o(oerr_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscomp++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] chan_byte(input int c);
    return byte_o[c*DW +: DW];
  endfunction

  // Returns just after a tick edge
  task automatic next_tick();
    @(negedge clk);
    while (!tick) @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1; line_i = '0; ack_i = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    repeat (3) next_tick();
  endtask

  // Logical bit values per tick; the pin carries the complement (R2)
  task automatic send(input logic [7:0] b [NCH], input logic [NCH-1:0] stopv,
                      input int off [NCH], input logic [NCH-1:0] en);
    for (int t = 0; t < 40; t++) begin
      for (int c = 0; c < NCH; c++) begin
        logic v;
        int rel;
        int bi;
        v = 1'b1;
        rel = t - off[c];
        if (en[c] && rel >= 0) begin
          bi = rel / 3;
          if (bi == 0)      v = 1'b0;
          else if (bi <= 8) v = b[c][bi-1];
          else if (bi == 9) v = stopv[c];
        end
        line_i[c] = ~v;
      end
      next_tick();
    end
  endtask

  task automatic pulse_ack(input logic [NCH-1:0] m);
    @(negedge clk); ack_i = m;
    @(negedge clk); ack_i = '0;
    @(negedge clk);
  endtask

  task automatic test_reset();
    do_reset();
    for (int c = 0; c < NCH; c++) check("R1 byte after reset", chan_byte(c), 8'h80);
    check("R1 rdy", rdy_o, 0);
    check("R1 ferr", ferr_o, 0);
    check("R1 oerr", oerr_o, 0);
  endtask

  task automatic test_parallel();
    logic [7:0] b [NCH];
    int off [NCH];
    do_reset();
    b = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80, 8'h3C, 8'hC3};
    for (int c = 0; c < NCH; c++) off[c] = c % 3;
    send(b, '1, off, '1);
    for (int c = 0; c < NCH; c++) check("R2 R3 received byte", chan_byte(c), b[c]);
    check("R5 all ready", rdy_o, 8'hFF);
    check("R3 no ferr", ferr_o, 0);
    check("R3 no oerr", oerr_o, 0);
    repeat (6) next_tick();
    check("R5 byte held until ack", chan_byte(2), 8'hA5);
    pulse_ack('1);
    check("R8 ready cleared", rdy_o, 0);
  endtask

  task automatic test_glitch();
    do_reset();
    // line 0 low for one tick, line 1 low for two ticks (R4)
    for (int t = 0; t < 40; t++) begin
      line_i = '0;
      if (t < 1) line_i[0] = 1'b1;
      if (t < 2) line_i[1] = 1'b1;
      next_tick();
    end
    check("R4 one-tick start rejected", rdy_o[0], 1'b0);
    check("R4 two-tick start accepted", rdy_o[1], 1'b1);
    check("R4 all-ones byte", chan_byte(1), 8'hFF);
    check("R4 idle line untouched", chan_byte(0), 8'h80);
  endtask

  task automatic test_frame_err_ack();
    logic [7:0] b [NCH];
    int off [NCH];
    do_reset();
    for (int c = 0; c < NCH; c++) begin b[c] = 8'h96; off[c] = 0; end
    send(b, 8'b1101_1111, off, 8'b0010_0100);
    check("R6 ferr on line 5 only", ferr_o, 8'b0010_0000);
    check("R6 ready with ferr", rdy_o, 8'b0010_0100);
    check("R6 byte kept", chan_byte(5), 8'h96);
    pulse_ack(8'b0010_0000);
    check("R8 ready left on line 2", rdy_o, 8'b0000_0100);
    check("R8 ferr cleared", ferr_o, 0);
    check("R8 byte reloaded", chan_byte(5), 8'h80);
    check("R8 other byte intact", chan_byte(2), 8'h96);
  endtask

  task automatic test_overrun();
    logic [7:0] b [NCH];
    int off [NCH];
    do_reset();
    for (int c = 0; c < NCH; c++) begin b[c] = 8'h4E; off[c] = 0; end
    send(b, '1, off, 8'b0000_1000);
    check("R7 no overrun yet", oerr_o, 0);
    send(b, '1, off, 8'b0000_1000);
    check("R7 overrun on line 3", oerr_o, 8'b0000_1000);
    check("R7 ready still set", rdy_o[3], 1'b1);
    pulse_ack(8'b0000_1000);
    check("R8 overrun cleared", oerr_o, 0);
  endtask

  initial begin
    #(8 * 150000);
    miscomp++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end

  initial begin
    test_reset();
    test_parallel();
    test_glitch();
    test_frame_err_ack();
    test_overrun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end
endmodule